// File: doc/BRIEF.md
# Reloading 24-bit tick timer

A memory-mapped down-counter that produces a periodic tick for system software. Once running, the counter steps down by one on every core clock cycle. When it reaches zero it reloads from a programmable value on the following cycle. The tick therefore repeats every reload+1 cycles: a reload value of 199 gives one tick in every 200 cycles.

Each step from 1 to 0 sets a sticky count flag. A read of the control/status register returns the flag and then clears it. When enabled, the same step also raises a level tick request, which stays high until the acknowledge input pulses. Software reaches the block through a simple synchronous register bus. The read data is combinational and is valid in the same cycle as the read strobe.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers are all 0, `tickReq` is low, and a read of control/status returns 0x0000_0004.
- R2: Control/status is at offset 0x10, reload at 0x14 and current value at 0x18. In control/status, bit 0 starts counting and bit 1 enables the tick request. Bit 2 always reads 1 and ignores writes, and bit 16 is the count flag. A write to bit 16 has no effect, every other bit reads 0, and a read at any unmapped offset returns 0.
- R3: Reload and current value are 24 bits wide, in bits 23:0. Bits 31:24 read as 0, and the upper bits of a reload write are dropped.
- R4: While running, a counter at 0 loads the reload value on the next cycle, and a nonzero counter decrements by one. With reload N-1 the counter steps from 1 to 0 once every N cycles.
- R5: While counting is disabled, the counter holds its value.
- R6: With a reload value of 0, a running counter stays at 0, the count flag is never set and no request is raised.
- R7: The count flag sets on the clock edge where the counter steps from 1 to 0. A control/status read returns the flag value from before the edge and clears it at that edge. If a set and a read-clear fall on the same edge, the set wins.
- R8: A write of any value to the current-value register clears the counter and the count flag to 0 and never raises `tickReq`.
- R9: A step from 1 to 0 raises `tickReq` on the next cycle only if bit 1 of control/status is 1. If bit 1 is 0, only the flag records the event.
- R10: `tickReq` stays high until a cycle with `tickAck` high, and it drops after that edge. A new tick on the same edge as the acknowledge keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the counter steps on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (12) | Register byte offset |
| busWe | input | 1 | Write strobe for one cycle |
| busWdata | input | DATA_W (32) | Write data |
| busRe | input | 1 | Read strobe for one cycle |
| busRdata | output | DATA_W (32) | Combinational read data; 0 when busRe is low |
| tickReq | output | 1 | Level tick request |
| tickAck | input | 1 | Acknowledge pulse that clears tickReq |

## Verification
The bench builds the block with its default parameters: a 24-bit counter and 12-bit offsets. It keeps the programmed reload values mostly between 0 and 7, so wraps happen every few cycles. Many wraps therefore land on the same edge as a status read, a current-value write, an acknowledge or a reload change. A reload write with all upper bits set checks the 24-bit truncation, and a large reload value shows the counter holding while counting is disabled.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic runEn;     // counting enabled
    logic curClear;  // current-value register written
    logic reloadWr;  // reload register written
  } tickStrobe_t;
endpackage

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickStrobe_t      strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] reloadVal,
  output logic             hitOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // step from 1 to 0 happens on this edge
  assign hitOne = strobes.runEn && !strobes.curClear && (countVal == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
    end else if (strobes.reloadWr) begin
      reloadVal <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobes.curClear) begin
      countVal <= '0;
    end else if (strobes.runEn) begin
      if (countVal == '0) countVal <= reloadVal;
      else                countVal <= countVal - ONE;
    end
  end
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int                  ADDR_W     = 12,
  parameter int                  DATA_W     = 32,
  parameter int                  CNT_W      = 24,
  parameter logic [ADDR_W-1:0]   CTRL_OFF   = 12'h010,
  parameter logic [ADDR_W-1:0]   RELOAD_OFF = 12'h014,
  parameter logic [ADDR_W-1:0]   CUR_OFF    = 12'h018,
  parameter int                  FLAG_BIT   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickAck,
  output logic              tickReq,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic              hitOne,
  output tickStrobe_t       strobes,
  output logic              cntFlag
);
  logic enReg;
  logic reqEnReg;
  logic selCtrl, selReload, selCur;
  logic ctrlRead;
  logic unusedBits;

  assign unusedBits = ^busWdata[DATA_W-1:2];

  assign selCtrl   = (busAddr == CTRL_OFF);
  assign selReload = (busAddr == RELOAD_OFF);
  assign selCur    = (busAddr == CUR_OFF);
  assign ctrlRead  = busRe && selCtrl;

  always_comb begin
    strobes          = '0;
    strobes.runEn    = enReg;
    strobes.curClear = busWe && selCur;
    strobes.reloadWr = busWe && selReload;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      reqEnReg <= 1'b0;
    end else if (busWe && selCtrl) begin
      enReg    <= busWdata[0];
      reqEnReg <= busWdata[1];
    end
  end

  // sticky flag: a write clear comes first, then a set, then a read clear
  always_ff @(posedge clk) begin
    if (!rstN)                 cntFlag <= 1'b0;
    else if (strobes.curClear) cntFlag <= 1'b0;
    else if (hitOne)           cntFlag <= 1'b1;
    else if (ctrlRead)         cntFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   tickReq <= 1'b0;
    else if (hitOne && reqEnReg) tickReq <= 1'b1;
    else if (tickAck)            tickReq <= 1'b0;
  end

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      if (selCtrl) begin
        busRdata[0]        = enReg;
        busRdata[1]        = reqEnReg;
        busRdata[2]        = 1'b1;
        busRdata[FLAG_BIT] = cntFlag;
      end else if (selReload) begin
        busRdata = DATA_W'(reloadVal);
      end else if (selCur) begin
        busRdata = DATA_W'(countVal);
      end
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              tickReq,
  input  logic              tickAck
);
  tickStrobe_t      strobes;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] reloadVal;
  logic             hitOne;
  logic             cntFlag;

  tick_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(busRdata),
    .tickAck(tickAck), .tickReq(tickReq),
    .countVal(countVal), .reloadVal(reloadVal), .hitOne(hitOne),
    .strobes(strobes), .cntFlag(cntFlag)
  );

  tick_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .wrData(busWdata[CNT_W-1:0]),
    .countVal(countVal), .reloadVal(reloadVal), .hitOne(hitOne)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRe,
  input logic [DATA_W-1:0] busRdata,
  input logic              tickReq,
  input logic              tickAck,
  input logic [CNT_W-1:0]  countVal,
  input logic              cntFlag,
  input tickStrobe_t       strb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr != ADDR_W'(16)) |-> (busRdata[DATA_W-1:CNT_W] == '0));

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (strb.runEn && !strb.curClear && countVal != '0) |=> (countVal == $past(countVal) - ONE));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.runEn && !strb.curClear) |=> $stable(countVal));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (strb.runEn && !strb.curClear && countVal == ONE) |=> cntFlag);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.curClear |=> (countVal == '0 && !cntFlag));

  a_r8_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (strb.curClear && !tickReq) |=> !tickReq);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (tickReq && !tickAck) |=> tickReq);
endmodule

bind tick_timer tick_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRe(busRe),
  .busRdata(busRdata), .tickReq(tickReq), .tickAck(tickAck),
  .countVal(countVal), .cntFlag(cntFlag), .strb(strobes)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] busAddr;
  logic        busWe, busRe, tickAck;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        tickReq;

  int vecs = 0;
  int errs = 0;

  bit        mEn, mTen, mFlag, mReq;
  bit [23:0] mCnt, mRel;

  always #4 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .tickReq(tickReq), .tickAck(tickAck)
  );

  function automatic logic [31:0] expRead(logic [11:0] a);
    case (a)
      12'h010: return {15'b0, mFlag, 13'b0, 1'b1, mTen, mEn};
      12'h014: return {8'b0, mRel};
      12'h018: return {8'b0, mCnt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep(bit we, bit re, logic [11:0] a, logic [31:0] d, bit ack);
    bit curWr, step;
    curWr = we && a == 12'h018;
    step  = mEn && mCnt == 24'd1 && !curWr;
    if (curWr)      mFlag = 0;
    else if (step)  mFlag = 1;
    else if (re && a == 12'h010) mFlag = 0;
    if (step && mTen) mReq = 1;
    else if (ack)     mReq = 0;
    if (curWr)      mCnt = 0;
    else if (mEn)   mCnt = (mCnt == 0) ? mRel : mCnt - 24'd1;
    if (we && a == 12'h014) mRel = d[23:0];
    if (we && a == 12'h010) begin mEn = d[0]; mTen = d[1]; end
  endtask

  task automatic cyc(bit we, bit re, logic [11:0] a, logic [31:0] d, bit ack, string tag);
    @(negedge clk);
    busWe = we; busRe = re; busAddr = a; busWdata = d; tickAck = ack;
    #1;
    if (re) check(tag, busRdata, expRead(a));
    check("R9/R10 tickReq", {31'b0, tickReq}, {31'b0, mReq});
    @(posedge clk);
    modelStep(we, re, a, d, ack);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag); cyc(1, 0, a, d, 0, tag); endtask
  task automatic rd(logic [11:0] a, string tag);                 cyc(0, 1, a, 0, 0, tag); endtask
  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 12'h0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 0; busWe = 0; busRe = 0; busAddr = 0; busWdata = 0; tickAck = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    rd(12'h010, "R1 ctrl");
    rd(12'h014, "R1 reload");
    rd(12'h018, "R1 current");

    // R2 field map: bit 16 and bit 2 writes ignored
    wr(12'h010, 32'hFFFF_FFF8, "R2");
    rd(12'h010, "R2 ctrl ignores upper");
    wr(12'h010, 32'h0000_0003, "R2");
    rd(12'h010, "R2 ctrl run+req");
    rd(12'h01C, "R2 unmapped");

    // R6 reload zero keeps counter at 0, no flag
    idle(10, "R6");
    rd(12'h018, "R6 current");
    rd(12'h010, "R6 flag");

    // R3 upper bits dropped
    wr(12'h010, 32'h0, "R3");
    wr(12'h014, 32'hFFAB_CDEF, "R3");
    rd(12'h014, "R3 reload");

    // R5 hold while disabled
    wr(12'h010, 32'h1, "R5");
    idle(4, "R5");
    wr(12'h010, 32'h0, "R5");
    rd(12'h018, "R5 current");
    idle(5, "R5");
    rd(12'h018, "R5 current held");

    // R8 write clears counter and flag
    wr(12'h018, 32'h0000_0123, "R8");
    rd(12'h018, "R8 current");
    rd(12'h010, "R8 flag");

    // R4 / R9 period with reload 3
    wr(12'h014, 32'd3, "R4");
    wr(12'h010, 32'h3, "R4");
    for (int i = 0; i < 12; i++) rd(12'h018, "R4 count");
    idle(3, "R10 held");
    cyc(0, 0, 12'h0, 0, 1, "R10 ack");
    wr(12'h018, 32'h0, "R8 no req");
    idle(2, "R8 no req");

    // R9 disabled request: flag only
    wr(12'h010, 32'h1, "R9");
    idle(10, "R9");
    rd(12'h010, "R9 flag only");

    // R7 read every cycle with reload 2
    wr(12'h014, 32'd2, "R7");
    for (int i = 0; i < 12; i++) rd(12'h010, "R7 flag");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit we, re, ack;
      logic [11:0] a;
      logic [31:0] d;
      we  = ($urandom % 12) == 0;
      re  = ($urandom % 2) == 1;
      ack = ($urandom % 6) == 0;
      a   = 12'h010 + 12'(4 * ($urandom % 4));
      d   = $urandom;
      if (a == 12'h014) d = ($urandom % 8) | (($urandom % 2) ? 32'hFF00_0000 : 32'h0);
      cyc(we, re, a, d, ack, "R4/R7/R10 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule